// File: doc/BRIEF.md
# Triplicated Memory with Background Voting Scrubber

This block is a single-port read/write memory built to tolerate radiation-induced bit flips that would otherwise pile up in stored words. Each word lives in three identical storage arrays. Every user write goes to all three arrays with the same address and data. Every user read returns the bitwise two-out-of-three majority of the three stored copies, one cycle after the request.

Voting on reads alone cannot stop a second upset from landing in a different copy of a word that has already lost one copy. To prevent this, a background scrub engine uses the clock cycles that carry no user request. It reads one address, votes across the three copies, and, when the copies disagree, writes the voted word back into all three arrays. It then moves on to the next address and wraps at the top. A saturating counter reports how many disagreeing words have been found, either by the scrubber or by user reads. An upset-injection port flips chosen bits in one chosen copy so that the repair path can be exercised at the ports.

The scrub engine is a four-state machine. IDLE moves to READ when scrubbing is enabled. READ returns to IDLE when scrubbing is disabled. READ moves to EVAL in a cycle with no user request, and that cycle issues the scrub read. EVAL moves to FIX when the copies disagree and no user write to the same address arrives in that cycle. In every other case EVAL advances the address and returns to READ. FIX stays in FIX while user requests keep the port busy. FIX returns to READ, advancing the address, once it writes the voted word in a free cycle, or at once if a user write to the same address makes the repair unnecessary.

Top module: `tsr_ram_top`

## Requirements
- R1: While reset is active and in the first cycle after it, `rd_valid`, `pass_done` and `corr_count` are all 0.
- R2: A user write (`req_valid`=1, `req_write`=1) stores `req_wdata` at `req_addr` in all three copies. A user read (`req_valid`=1, `req_write`=0) raises `rd_valid` for exactly the next cycle, and never at any other time.
- R3: When `rd_valid` is high, `rd_data` is the bitwise majority of the three copies at the read address, taken before any write in the same cycle. A word with upsets in only one copy therefore reads back correctly. While `rd_valid` is low, `rd_data` is 0.
- R4: User requests take priority. The scrubber reads or writes the arrays only in cycles where `req_valid` is 0, and user read results are never disturbed by scrub activity.
- R5: A scrub step reads its address in one cycle and evaluates the three copies in the next cycle. If they disagree, it writes the voted word into all three copies in the first following cycle with no user request. A user write to that same address while the repair is pending cancels the write-back.
- R6: `corr_count` rises by exactly one, in the cycle after the data becomes available, for each scrub evaluation or user read that finds the copies not all equal. It holds at its maximum value 2^CNT_W-1.
- R7: The scrub address starts at 0, steps by one per completed scrub step, and wraps from DEPTH-1 to 0. `pass_done` is high for one cycle right after the step at address DEPTH-1 completes.
- R8: With `scrub_en` low, the engine finishes any step in progress and then neither reads nor repairs. A corrupted word stays corrupted, and every user read of it counts again.
- R9: `inj_valid` XORs `inj_mask` into copy `inj_copy` (0, 1 or 2) at `inj_addr`. The value 3 for `inj_copy` selects no copy. An injection is dropped in any cycle where the arrays are written.
- R10: After one complete scrub pass over a memory where each word had upsets in at most one copy, all three copies agree everywhere, and reading every address adds nothing to `corr_count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | User request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | User word address |
| req_wdata | input | DATA_W | User write data |
| scrub_en | input | 1 | Enables background scrubbing |
| inj_valid | input | 1 | Apply an upset this cycle |
| inj_copy | input | 2 | Copy to upset (0..2; 3 = none) |
| inj_addr | input | AW | Address to upset |
| inj_mask | input | DATA_W | Bits to flip |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Voted read data |
| corr_count | output | CNT_W | Saturating count of disagreeing words found |
| pass_done | output | 1 | Pulse after a full scrub pass |

## Verification
The bench builds the block with DATA_W=8, DEPTH=32 and CNT_W=4. The 32-word depth brings many complete scrub passes and address wraps within a short run. The 4-bit counter lets random upsets drive `corr_count` into saturation. A behavioural model of the three copies and of the scrub stepping is compared on every clock. Random traffic mixes user requests, upsets and scrubbing, so repairs that are delayed or cancelled by user writes do occur. Directed phases first show that an unscrubbed upset persists, then show that one pass clears all single-copy upsets.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int COPIES = 3;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_READ = 2'd1,
        SC_EVAL = 2'd2,
        SC_FIX  = 2'd3
    } scrub_state_e;

endpackage

// File: rtl/tsr_bank.sv
module tsr_bank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    input  logic              inj_en,
    input  logic [AW-1:0]     inj_addr,
    input  logic [DATA_W-1:0] inj_mask,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // One write port: a functional write wins over an upset injection.
    // The read is read-first with respect to a same-cycle write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end else if (inj_en) begin
            mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/tsr_voter.sv
module tsr_voter #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] cp_a,
    input  logic [DATA_W-1:0] cp_b,
    input  logic [DATA_W-1:0] cp_c,
    output logic [DATA_W-1:0] voted,
    output logic              disagree
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign voted[i] = (cp_a[i] & cp_b[i]) | (cp_a[i] & cp_c[i]) | (cp_b[i] & cp_c[i]);
    end

    assign disagree = |((cp_a ^ cp_b) | (cp_a ^ cp_c));

endmodule

// File: rtl/tsr_scrub_fsm.sv
module tsr_scrub_fsm
    import tsr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scrub_en,
    input  logic              user_acc,
    input  logic              user_wr,
    input  logic [AW-1:0]     user_addr,
    input  logic              eval_disagree,
    input  logic [DATA_W-1:0] eval_word,
    output scrub_state_e      state,
    output logic [AW-1:0]     scrub_addr,
    output logic              scrub_rd,
    output logic              fix_we,
    output logic [DATA_W-1:0] fix_word,
    output logic              pass_done
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    scrub_state_e      state_q, state_d;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] fix_q;
    logic              pass_q;
    logic              advance;
    logic              hit_wr;

    assign hit_wr = user_acc && user_wr && (user_addr == addr_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        unique case (state_q)
            SC_IDLE: begin
                if (scrub_en) state_d = SC_READ;
            end
            SC_READ: begin
                if (!scrub_en)      state_d = SC_IDLE;
                else if (!user_acc) state_d = SC_EVAL;
            end
            SC_EVAL: begin
                if (eval_disagree && !hit_wr) begin
                    state_d = SC_FIX;
                end else begin
                    state_d = SC_READ;
                    advance = 1'b1;
                end
            end
            SC_FIX: begin
                if (!user_acc || hit_wr) begin
                    state_d = SC_READ;
                    advance = 1'b1;
                end
            end
            default: state_d = SC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            addr_q  <= '0;
            fix_q   <= '0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pass_q  <= advance && (addr_q == LAST_ADDR);
            if (advance) addr_q <= (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
            if (state_q == SC_EVAL) fix_q <= eval_word;
        end
    end

    // Outputs
    always_comb begin
        state      = state_q;
        scrub_addr = addr_q;
        fix_word   = fix_q;
        pass_done  = pass_q;
        scrub_rd   = (state_q == SC_READ) && scrub_en && !user_acc;
        fix_we     = (state_q == SC_FIX) && !user_acc;
    end

endmodule

// File: rtl/tsr_ram_top.sv
module tsr_ram_top
    import tsr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    parameter int CNT_W  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              scrub_en,
    input  logic              inj_valid,
    input  logic [1:0]        inj_copy,
    input  logic [AW-1:0]     inj_addr,
    input  logic [DATA_W-1:0] inj_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  corr_count,
    output logic              pass_done
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    scrub_state_e      state_w;
    logic [AW-1:0]     scrub_addr_w;
    logic              scrub_rd_w;
    logic              fix_we_w;
    logic [DATA_W-1:0] fix_word_w;
    logic [DATA_W-1:0] bank_rd [COPIES];
    logic [DATA_W-1:0] voted_w;
    logic              disagree_w;
    logic              bank_we;
    logic [AW-1:0]     bank_waddr;
    logic [DATA_W-1:0] bank_wdata;
    logic [AW-1:0]     bank_raddr;
    logic              rd_valid_q;
    logic [CNT_W-1:0]  corr_q;
    logic              found_bad;

    assign bank_we    = (req_valid && req_write) || fix_we_w;
    assign bank_waddr = fix_we_w ? scrub_addr_w : req_addr;
    assign bank_wdata = fix_we_w ? fix_word_w   : req_wdata;
    assign bank_raddr = req_valid ? req_addr : scrub_addr_w;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        tsr_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) bank_i (
            .clk      (clk),
            .we       (bank_we),
            .waddr    (bank_waddr),
            .wdata    (bank_wdata),
            .raddr    (bank_raddr),
            .inj_en   (inj_valid && (inj_copy == 2'(c))),
            .inj_addr (inj_addr),
            .inj_mask (inj_mask),
            .rdata    (bank_rd[c])
        );
    end

    tsr_voter #(.DATA_W(DATA_W)) voter_i (
        .cp_a     (bank_rd[0]),
        .cp_b     (bank_rd[1]),
        .cp_c     (bank_rd[2]),
        .voted    (voted_w),
        .disagree (disagree_w)
    );

    tsr_scrub_fsm #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scrub_en      (scrub_en),
        .user_acc      (req_valid),
        .user_wr       (req_write),
        .user_addr     (req_addr),
        .eval_disagree (disagree_w),
        .eval_word     (voted_w),
        .state         (state_w),
        .scrub_addr    (scrub_addr_w),
        .scrub_rd      (scrub_rd_w),
        .fix_we        (fix_we_w),
        .fix_word      (fix_word_w),
        .pass_done     (pass_done)
    );

    // Bank outputs carry either user read data or scrub read data, never both.
    assign found_bad = disagree_w && (rd_valid_q || (state_w == SC_EVAL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            corr_q     <= '0;
        end else begin
            rd_valid_q <= req_valid && !req_write;
            if (found_bad && (corr_q != CNT_MAX)) corr_q <= corr_q + 1'b1;
        end
    end

    assign rd_valid   = rd_valid_q;
    assign rd_data    = rd_valid_q ? voted_w : '0;
    assign corr_count = corr_q;

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker
    import tsr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             rd_valid,
    input logic             pass_done,
    input logic [CNT_W-1:0] corr_count,
    input scrub_state_e     state,
    input logic             scrub_rd,
    input logic             fix_we
);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);  // R2
    AST_VALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));  // R2
    AST_SCRUB_READ_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_rd |-> !req_valid);  // R4
    AST_FIX_WRITE_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        fix_we |-> !req_valid);  // R4
    AST_EVAL_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_rd |=> (state == SC_EVAL));  // R5
    AST_FIX_FROM_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_FIX) |-> ($past(state) == SC_EVAL || $past(state) == SC_FIX));  // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_count == $past(corr_count)) || (corr_count == CNT_W'($past(corr_count) + 1'b1)));  // R6
    AST_PASS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);  // R7

endmodule

bind tsr_ram_top tsr_checker #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rd_valid   (rd_valid),
    .pass_done  (pass_done),
    .corr_count (corr_count),
    .state      (state_w),
    .scrub_rd   (scrub_rd_w),
    .fix_we     (fix_we_w)
);

// File: tb/tsr_ram_top_tb_top.sv
module tsr_ram_top_tb_top;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 32;
    localparam int CNT_W  = 4;
    localparam int AW     = $clog2(DEPTH);
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              scrub_en = 1'b0;
    logic              inj_valid = 1'b0;
    logic [1:0]        inj_copy = 2'd0;
    logic [AW-1:0]     inj_addr = '0;
    logic [DATA_W-1:0] inj_mask = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  corr_count;
    logic              pass_done;

    int checks = 0;
    int fails  = 0;
    bit started = 0;

    always #10 clk = ~clk;  // 50 MHz

    tsr_ram_top #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .scrub_en(scrub_en),
        .inj_valid(inj_valid), .inj_copy(inj_copy), .inj_addr(inj_addr), .inj_mask(inj_mask),
        .rd_valid(rd_valid), .rd_data(rd_data), .corr_count(corr_count), .pass_done(pass_done)
    );

    // ---------------- behavioural reference model ----------------
    int  cp [3][DEPTH];
    int  m_st = 0, m_sa = 0, m_fix = 0, m_cnt = 0, m_evw = 0;
    bit  m_evmis = 0, m_pendv = 0, m_pendmis = 0;
    bit  e_rdv = 0, e_pass = 0;
    int  e_rd = 0;

    function automatic int vote(int a);
        int x = cp[0][a], y = cp[1][a], z = cp[2][a];
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic bit differs(int a);
        return (cp[0][a] != cp[1][a]) || (cp[0][a] != cp[2][a]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sa = 0; m_cnt = 0; m_pendv = 0; m_pendmis = 0;
            e_rdv = 0; e_pass = 0;
        end else begin
            bit nv, nmis, wr_any, hit, adv;
            nv = 0; nmis = 0; wr_any = 0; adv = 0;
            if (m_pendv && m_pendmis && m_cnt < MAXC) m_cnt++;
            e_rdv = 0; e_pass = 0;
            hit = req_valid && req_write && (int'(req_addr) == m_sa);
            if (req_valid && !req_write) begin
                e_rdv = 1; e_rd = vote(int'(req_addr));
                nv = 1; nmis = differs(int'(req_addr));
            end
            case (m_st)
                0: if (scrub_en) m_st = 1;
                1: if (!scrub_en) m_st = 0;
                   else if (!req_valid) begin
                       nv = 1; nmis = differs(m_sa);
                       m_evmis = nmis; m_evw = vote(m_sa); m_st = 2;
                   end
                2: if (m_evmis && !hit) begin m_fix = m_evw; m_st = 3; end
                   else begin adv = 1; m_st = 1; end
                default: if (!req_valid) begin
                       for (int c = 0; c < 3; c++) cp[c][m_sa] = m_fix;
                       wr_any = 1; adv = 1; m_st = 1;
                   end else if (hit) begin adv = 1; m_st = 1; end
            endcase
            if (adv) begin
                e_pass = (m_sa == DEPTH - 1);
                m_sa = (m_sa + 1) % DEPTH;
            end
            if (req_valid && req_write) begin
                for (int c = 0; c < 3; c++) cp[c][int'(req_addr)] = int'(req_wdata);
                wr_any = 1;
            end
            if (inj_valid && inj_copy != 2'd3 && !wr_any)
                cp[inj_copy][int'(inj_addr)] = cp[inj_copy][int'(inj_addr)] ^ int'(inj_mask);
            m_pendv = nv; m_pendmis = nmis;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && started) begin
            check(rd_valid == e_rdv, "R2 rd_valid", int'(rd_valid), int'(e_rdv));
            if (e_rdv) check(int'(rd_data) == e_rd, "R3 R4 rd_data", int'(rd_data), e_rd);
            else       check(rd_data == '0, "R3 idle rd_data", int'(rd_data), 0);
            check(int'(corr_count) == m_cnt, "R6 corr_count", int'(corr_count), m_cnt);
            check(pass_done == e_pass, "R7 pass_done", int'(pass_done), int'(e_pass));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cyc();
        @(negedge clk);
        req_valid = 0; req_write = 0; inj_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) cyc();
    endtask

    task automatic wr(int a, int d);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = DATA_W'(d);
        cyc();
    endtask

    task automatic rd(int a);
        req_valid = 1; req_write = 0; req_addr = AW'(a);
        cyc();
    endtask

    task automatic upset(int c, int a, int m);
        inj_valid = 1; inj_copy = 2'(c); inj_addr = AW'(a); inj_mask = DATA_W'(m);
        cyc();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int c0;
        int np;
        repeat (4) @(negedge clk);
        // r1_ reset state
        check(rd_valid == 0, "R1 rd_valid in reset", int'(rd_valid), 0);
        check(corr_count == 0, "R1 corr_count in reset", int'(corr_count), 0);
        check(pass_done == 0, "R1 pass_done in reset", int'(pass_done), 0);
        rst_n = 1;
        started = 1;
        @(negedge clk);
        check(corr_count == 0 && rd_valid == 0, "R1 after release", int'(corr_count), 0);

        // R2: fill and read back
        for (int a = 0; a < DEPTH; a++) wr(a, (a * 37 + 5) & 8'hFF);
        for (int a = 0; a < DEPTH; a++) rd(a);
        idle(2);

        // R3: single-copy upset is voted out on read and counted
        c0 = int'(corr_count);
        upset(0, 3, 8'hFF);
        rd(3); idle(2);
        check(int'(corr_count) == c0 + 1, "R3 single-copy upset counted", int'(corr_count), c0 + 1);

        // R9: copy select 3 hits nothing
        c0 = int'(corr_count);
        upset(3, 4, 8'h0F);
        rd(4); idle(2);
        check(int'(corr_count) == c0, "R9 copy 3 ignored", int'(corr_count), c0);

        // R8: with scrubbing off the upset persists and is counted on every read
        c0 = int'(corr_count);
        idle(20);
        rd(3); idle(1); rd(3); idle(2);
        check(int'(corr_count) == c0 + 2, "R8 no repair when scrub off", int'(corr_count), c0 + 2);

        // R5 / R10: upsets in one copy each, then full scrub pass
        for (int i = 0; i < 6; i++) upset(i % 3, 8 + 3 * i, 1 << i);
        c0 = int'(corr_count);
        scrub_en = 1;
        np = 0;
        while (np < 2) begin
            cyc();
            if (pass_done) np++;
        end
        scrub_en = 0;
        idle(4);
        check(int'(corr_count) == c0 + 7, "R5 each bad word repaired once", int'(corr_count), c0 + 7);
        c0 = int'(corr_count);
        for (int a = 0; a < DEPTH; a++) rd(a);
        idle(2);
        check(int'(corr_count) == c0, "R10 copies agree after pass", int'(corr_count), c0);

        // Random mix of traffic, upsets and scrubbing
        scrub_en = 1;
        for (int i = 0; i < 3000; i++) begin
            req_valid = ($urandom % 2) == 0;
            req_write = ($urandom % 10) < 3;
            req_addr  = AW'($urandom);
            req_wdata = DATA_W'($urandom);
            inj_valid = ($urandom % 10) == 0;
            inj_copy  = 2'($urandom);
            inj_addr  = AW'($urandom);
            inj_mask  = DATA_W'(1 << ($urandom % DATA_W));
            if (($urandom % 50) == 0) scrub_en = ~scrub_en;
            cyc();
        end
        scrub_en = 1;
        idle(10);
        check(int'(corr_count) == MAXC, "R6 counter saturates", int'(corr_count), MAXC);

        summary();
        $finish;
    end

endmodule